// File: doc/BRIEF.md
# Inverse 5/3 Integer Lifting Stage

This block rebuilds a one-dimensional run of integer samples from its interleaved wavelet coefficients, the inverse of a reversible 5/3 lifting analysis stage. The run sits in a shared register file. Location `first + k*stride` holds sample position k. Even positions hold low-pass coefficients and odd positions hold high-pass coefficients. The block reads the coefficients through a combinational read port and overwrites each location with the rebuilt sample through a write port, so the transform is done in place.

A caller places the run bounds and the stride on the address inputs and pulses `start_i` while `ready_o` is high. The block then makes two passes over the run. The first pass removes the update step and restores every even sample. The second pass removes the predict step and restores every odd sample, using the even samples the first pass wrote. At each end of the run the missing neighbour is taken by whole-sample symmetric mirroring. This is the same extension the analysis stage uses, so a forward transform followed by this inverse returns the original integers exactly.

Top module: `isyn_inv53`

## Requirements
- R1: After reset, `ready_o` is 1 and `wr_en_o` is 0.
- R2: A `start_i` pulse seen while `ready_o` is 1 is accepted, and `ready_o` is 0 in the next cycle. `ready_o` stays 0 until the run is finished. A `start_i` pulse or a change of the address inputs while busy has no effect on the run in progress.
- R3: Sample position k of a run of L samples (L = (last-first)/stride + 1, L >= 2) lives at address first + k*stride. Each of these L addresses is written exactly once per run, no two writes fall in consecutive cycles, and no other address is written.
- R4: An even position 2n is written with s[n] - floor((dl + dr + 2)/4), where dl and dr are the high-pass values at positions 2n-1 and 2n+1. At position 0, dl is replaced by dr.
- R5: An odd position 2n+1 is written with d[n] + floor((xl + xr)/2), where xl and xr are the rebuilt samples at positions 2n and 2n+2. When position 2n+2 lies past the end of the run, xr is replaced by xl.
- R6: When L is odd, the last even position has no right high-pass neighbour, so dr is replaced by dl.
- R7: Every even position of a run is written before any odd position.
- R8: Taking a reversible 5/3 forward transform with the same mirroring and then running this block returns the original signed integers bit-exactly, for negative values too (floor rounds toward minus infinity).
- R9: Register-file locations outside the run, including those between strided samples, keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken while ready |
| ready_o | output | 1 | High when idle and able to accept a run |
| first_addr_i | input | AW | Address of sample position 0 |
| last_addr_i | input | AW | Address of the last sample position |
| stride_i | input | AW | Address distance between neighbouring positions (nonzero) |
| rd_addr_o | output | AW | Register-file read address |
| rd_data_i | input | DW | Read data for `rd_addr_o`, same cycle |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Rebuilt signed sample |

## Verification
The bench builds the block with 12-bit data and 5-bit addresses against a 32-entry register file model. This is small enough to sweep every combination of first address 0 to 3, stride 1 to 3 and run length 2 to 9. The sweep covers both parities of run length, so each mirroring case at both ends is reached, and the strides leave gaps between samples in which stray writes would show. Patterns of random signed values, all-negative values, extreme alternation and ramps are run forward in the bench and then restored by the block. Busy-time start pulses with different addresses are injected to show that they are ignored.

// File: rtl/isyn_pkg.sv
package isyn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EV_CTR,
        ST_EV_NB,
        ST_EV_WR,
        ST_OD_SEED,
        ST_OD_CTR,
        ST_OD_NB,
        ST_OD_WR
    } isyn_state_e;

endpackage

// File: rtl/isyn_lift_kern.sv
// One inverse lifting step: a center coefficient corrected by two neighbours.
// ODD=0 removes the update step, ODD=1 removes the predict step.
module isyn_lift_kern #(
    parameter int DW  = 12,
    parameter bit ODD = 1'b0
) (
    input  logic [DW-1:0] ctr_i,
    input  logic [DW-1:0] nb_lo_i,
    input  logic [DW-1:0] nb_hi_i,
    output logic [DW-1:0] res_o
);
    localparam int EW = DW + 2;
    localparam logic signed [EW-1:0] RND = EW'(2);

    logic signed [EW-1:0] ce, lo, hi, sum, res;

    assign ce  = {{2{ctr_i[DW-1]}}, ctr_i};
    assign lo  = {{2{nb_lo_i[DW-1]}}, nb_lo_i};
    assign hi  = {{2{nb_hi_i[DW-1]}}, nb_hi_i};
    assign sum = lo + hi;

    generate
        if (ODD) begin : g_predict
            assign res = ce + (sum >>> 1);
        end else begin : g_update
            assign res = ce - ((sum + RND) >>> 2);
        end
    endgenerate

    assign res_o = res[DW-1:0];
endmodule

// File: rtl/isyn_stride.sv
// Strided address arithmetic for the current position.
module isyn_stride #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] last_i,
    output logic [AW-1:0] nxt1_o,
    output logic [AW-1:0] nxt2_o,
    output logic          at_last_o,
    output logic          pen_o
);
    logic [AW-1:0] step2;

    assign step2     = {step_i[AW-2:0], 1'b0};
    assign nxt1_o    = cur_i + step_i;
    assign nxt2_o    = cur_i + step2;
    assign at_last_o = (cur_i == last_i);
    assign pen_o     = (nxt1_o == last_i);
endmodule

// File: rtl/isyn_inv53.sv
module isyn_inv53
    import isyn_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    output logic          ready_o,
    input  logic [AW-1:0] first_addr_i,
    input  logic [AW-1:0] last_addr_i,
    input  logic [AW-1:0] stride_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    typedef struct packed {
        isyn_state_e   st;
        logic [AW-1:0] cur;
        logic [AW-1:0] base;
        logic [AW-1:0] last;
        logic [AW-1:0] step;
        logic [DW-1:0] lft;
        logic [DW-1:0] mid;
        logic [DW-1:0] rgt;
    } isyn_regs_t;

    isyn_regs_t r_d, r_q;

    logic [AW-1:0] nxt1, nxt2;
    logic          at_last, pen;
    logic [DW-1:0] even_val, odd_val;

    isyn_stride #(.AW(AW)) u_stride (
        .cur_i     (r_q.cur),
        .step_i    (r_q.step),
        .last_i    (r_q.last),
        .nxt1_o    (nxt1),
        .nxt2_o    (nxt2),
        .at_last_o (at_last),
        .pen_o     (pen)
    );

    isyn_lift_kern #(.DW(DW), .ODD(1'b0)) u_even (
        .ctr_i   (r_q.mid),
        .nb_lo_i (r_q.lft),
        .nb_hi_i (r_q.rgt),
        .res_o   (even_val)
    );

    isyn_lift_kern #(.DW(DW), .ODD(1'b1)) u_odd (
        .ctr_i   (r_q.mid),
        .nb_lo_i (r_q.lft),
        .nb_hi_i (r_q.rgt),
        .res_o   (odd_val)
    );

    always_comb begin
        r_d       = r_q;
        rd_addr_o = r_q.cur;
        wr_en_o   = 1'b0;
        wr_addr_o = r_q.cur;
        wr_data_o = even_val;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_EV_CTR;
                    r_d.cur  = first_addr_i;
                    r_d.base = first_addr_i;
                    r_d.last = last_addr_i;
                    r_d.step = stride_i;
                end
            end
            // even pass: low-pass value, then right high-pass neighbour
            ST_EV_CTR: begin
                r_d.mid = rd_data_i;
                if (at_last) begin
                    r_d.rgt = r_q.lft;
                    r_d.st  = ST_EV_WR;
                end else begin
                    r_d.st = ST_EV_NB;
                end
            end
            ST_EV_NB: begin
                rd_addr_o = nxt1;
                r_d.rgt   = rd_data_i;
                if (r_q.cur == r_q.base) begin
                    r_d.lft = rd_data_i;
                end
                r_d.st = ST_EV_WR;
            end
            ST_EV_WR: begin
                wr_en_o   = 1'b1;
                wr_data_o = even_val;
                r_d.lft   = r_q.rgt;
                if (at_last || pen) begin
                    r_d.cur = r_q.base;
                    r_d.st  = ST_OD_SEED;
                end else begin
                    r_d.cur = nxt2;
                    r_d.st  = ST_EV_CTR;
                end
            end
            // odd pass: seed with rebuilt sample 0, then walk odd positions
            ST_OD_SEED: begin
                r_d.lft = rd_data_i;
                r_d.cur = nxt1;
                r_d.st  = ST_OD_CTR;
            end
            ST_OD_CTR: begin
                r_d.mid = rd_data_i;
                if (at_last) begin
                    r_d.rgt = r_q.lft;
                    r_d.st  = ST_OD_WR;
                end else begin
                    r_d.st = ST_OD_NB;
                end
            end
            ST_OD_NB: begin
                rd_addr_o = nxt1;
                r_d.rgt   = rd_data_i;
                r_d.st    = ST_OD_WR;
            end
            ST_OD_WR: begin
                wr_en_o   = 1'b1;
                wr_data_o = odd_val;
                r_d.lft   = r_q.rgt;
                if (at_last || pen) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cur = nxt2;
                    r_d.st  = ST_OD_CTR;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o = (r_q.st == ST_IDLE);
endmodule

// File: rtl/isyn_inv53_chk.sv
module isyn_inv53_chk #(
    parameter int DW = 12,
    parameter int AW = 5
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          ready_o,
    input logic [AW-1:0] first_addr_i,
    input logic [AW-1:0] last_addr_i,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [DW-1:0] wr_data_o
);
    logic [AW-1:0] lo_q, hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q <= '0;
            hi_q <= '1;
        end else if (ready_o && start_i) begin
            lo_q <= first_addr_i;
            hi_q <= last_addr_i;
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && start_i) |=> !ready_o); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !start_i) |=> ready_o); // R2

    AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> !ready_o); // R2

    AST_WRITES_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |=> !wr_en_o); // R3

    AST_WRITE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (wr_addr_o >= lo_q && wr_addr_o <= hi_q)); // R3

    AST_DATA_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> !$isunknown(wr_data_o)); // R8
endmodule

bind isyn_inv53 isyn_inv53_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .ready_o      (ready_o),
    .first_addr_i (first_addr_i),
    .last_addr_i  (last_addr_i),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o)
);

// File: tb/isyn_inv53_test.sv
module isyn_inv53_test;
    localparam int DW    = 12;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready;
    logic [AW-1:0] first_a = '0, last_a = '0, stride = 1;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    logic signed [DW-1:0] mem [DEPTH];

    always #2.5 clk = ~clk;

    isyn_inv53 #(.DW(DW), .AW(AW)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .ready_o      (ready),
        .first_addr_i (first_a),
        .last_addr_i  (last_a),
        .stride_i     (stride),
        .rd_addr_o    (rd_addr),
        .rd_data_i    (rd_data),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data)
    );

    assign rd_data = mem[rd_addr];

    int n_run = 0, n_fail = 0, cycles = 0;
    int xv [16];
    int cv [16];
    int cur_first, cur_step, cur_len;
    int wr_cnt, err_r4, err_r5, err_r6, err_order, err_stray, odd_seen;
    int bad_act, bad_exp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // register-file model and write log, checked against the original samples
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wr_en) begin
            int off, pos;
            mem[wr_addr] <= wr_data;
            wr_cnt++;
            off = int'(wr_addr) - cur_first;
            if (off < 0 || (off % cur_step) != 0 || off / cur_step >= cur_len) begin
                err_stray++;
            end else begin
                pos = off / cur_step;
                if ((pos % 2) == 1) begin
                    odd_seen = 1;
                    if ($signed(wr_data) != DW'(xv[pos])) begin
                        err_r5++; bad_act = int'($signed(wr_data)); bad_exp = xv[pos];
                    end
                end else begin
                    if (odd_seen != 0) err_order++;
                    if ($signed(wr_data) != DW'(xv[pos])) begin
                        bad_act = int'($signed(wr_data)); bad_exp = xv[pos];
                        if ((cur_len % 2) == 1 && pos == cur_len - 1) err_r6++;
                        else err_r4++;
                    end
                end
            end
        end
    end

    function automatic int bg(input int a);
        return ((a * 37 + 11) % 900) - 450;
    endfunction

    // forward 5/3 lifting with whole-sample symmetric ends
    task automatic forward(input int len);
        for (int k = 1; k < len; k += 2) begin
            int l, r;
            l = xv[k-1];
            r = (k + 1 < len) ? xv[k+1] : xv[k-1];
            cv[k] = xv[k] - ((l + r) >>> 1);
        end
        for (int k = 0; k < len; k += 2) begin
            int dl, dr;
            dl = (k > 0) ? cv[k-1] : cv[k+1];
            dr = (k + 1 < len) ? cv[k+1] : cv[k-1];
            cv[k] = xv[k] + ((dl + dr + 2) >>> 2);
        end
    endtask

    task automatic run_cfg(input int f, input int s, input int len, input int pat);
        int waited;
        string tag;
        for (int a = 0; a < DEPTH; a++) mem[a] = DW'(bg(a));
        for (int k = 0; k < len; k++) begin
            case (pat)
                0: xv[k] = int'($urandom_range(400)) - 200;
                1: xv[k] = (k % 2 == 0) ? 255 : -256;
                2: xv[k] = -1 - int'($urandom_range(255));
                default: xv[k] = k * 29 - 100;
            endcase
        end
        forward(len);
        for (int k = 0; k < len; k++) mem[f + k*s] = DW'(cv[k]);
        cur_first = f; cur_step = s; cur_len = len;
        wr_cnt = 0; err_r4 = 0; err_r5 = 0; err_r6 = 0;
        err_order = 0; err_stray = 0; odd_seen = 0;
        tag = $sformatf("f=%0d s=%0d L=%0d p=%0d", f, s, len, pat);

        first_a = AW'(f); last_a = AW'(f + (len-1)*s); stride = AW'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, {"R2 ready drops ", tag}, int'(ready), 0);
        if (pat == 1) begin
            // busy-time request with other bounds must be ignored
            first_a = AW'(0); last_a = AW'(DEPTH-1); stride = AW'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(ready == 1'b0, {"R2 busy start ", tag}, int'(ready), 0);
        end
        waited = 0;
        while (!ready && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 400, {"R2 completion ", tag}, waited, 0);
        chk(wr_cnt == len, {"R3 write count ", tag}, wr_cnt, len);
        chk(err_stray == 0, {"R3 stray writes ", tag}, err_stray, 0);
        chk(err_r4 == 0, {"R4 even value ", tag}, bad_act, bad_exp);
        chk(err_r5 == 0, {"R5 odd value ", tag}, bad_act, bad_exp);
        if (len % 2 == 1)
            chk(err_r6 == 0, {"R6 odd-length end ", tag}, bad_act, bad_exp);
        chk(err_order == 0, {"R7 pass order ", tag}, err_order, 0);
        for (int k = 0; k < len; k++)
            chk(mem[f + k*s] == DW'(xv[k]), {"R8 round trip ", tag},
                int'(mem[f + k*s]), xv[k]);
        for (int a = 0; a < DEPTH; a++) begin
            int off;
            off = a - f;
            if (off < 0 || off % s != 0 || off / s >= len)
                chk(mem[a] == DW'(bg(a)), {"R9 untouched ", tag}, int'(mem[a]), bg(a));
        end
    endtask

    initial begin
        int cfg;
        cur_first = 0; cur_step = 1; cur_len = 0;
        wr_cnt = 0; err_r4 = 0; err_r5 = 0; err_r6 = 0;
        err_order = 0; err_stray = 0; odd_seen = 0; bad_act = 0; bad_exp = 0;
        for (int a = 0; a < DEPTH; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R1 no write in reset", int'(wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        chk(wr_en == 1'b0, "R1 write idle after reset", int'(wr_en), 0);
        repeat (2) @(negedge clk);
        chk(ready == 1'b1, "R2 idle without start", int'(ready), 1);
        cfg = 0;
        for (int f = 0; f < 4; f++)
            for (int s = 1; s < 4; s++)
                for (int len = 2; len < 10; len++) begin
                    run_cfg(f, s, len, cfg % 4);
                    cfg++;
                    @(negedge clk);
                end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule